// File: doc/BRIEF.md
# Watchpoint Chaining and Counter Unit

This block sits in a processor's debug logic downstream of the matchpoint comparators. Each cycle it takes eight comparator hit bits, an external watchpoint line and the contents of two counter registers, and forms eleven watchpoints. Watchpoint i can stand alone, or be combined through AND or OR with watchpoint i-1, so long chains of conditions fold into one decision. Two watchpoints are fed back from the counters: each fires when its counter's running count reaches the programmed match value.

Matching watchpoints can bump one of the two counters and can ask for a debug break. A single-step control forces a break on every instruction fetch. A global debug enable and an in-reset flag suppress all of it. The status of all eleven watchpoints for the evaluated cycle is presented one clock later, next to the break request. The status is rebuilt every cycle and keeps no history.

Top module: `dbg_wp_chain`

## Requirements
- R1: After a synchronous active-low reset, `brk_req`, `wp_status` and both counter registers read zero.
- R2: Watchpoint i (0 to 7) takes its own condition from `mp_hit[i]`. Watchpoint 8 takes its own condition from counter 0 having count (bits 15:0) equal to match (bits 31:16). Watchpoint 9 does the same for counter 1, and watchpoint 10 takes it from `ext_wp`. Bit i of `wp_status` shows watchpoint i for the inputs sampled one clock earlier.
- R3: The mode of watchpoint i is held in `chain_mode[2i+1:2i]`. Mode 0 gives the own condition. Mode 1 gives own AND the previous watchpoint, mode 2 gives own OR the previous watchpoint, and mode 3 never matches. The previous watchpoint of i is i-1. For watchpoint 0 it is its own condition.
- R4: Bit i of `cnt_assign` routes watchpoint i to counter 0 (bit clear) or counter 1 (bit set). When `cnt_en[k]` is set and at least one matching watchpoint routes to counter k, the count of counter k goes up by exactly one at the next edge, however many watchpoints match. It wraps from 0xFFFF to 0, and its match field does not change.
- R5: `cnt_wr[k]` loads the whole 32-bit `cnt_wdata` into counter k at the next edge, and this takes priority over an increment in the same cycle.
- R6: `brk_req` goes high one clock after a cycle in which some matching watchpoint i has `brk_gen[i]` set.
- R7: `brk_req` goes high one clock after a cycle with `single_step` and `ifetch` both high, regardless of the watchpoints.
- R8: While `dbg_en` is low or `in_reset` is high, the next `brk_req` and `wp_status` are zero and no counter increments.
- R9: When every bit of `brk_gen` and `cnt_assign` is zero, no watchpoint is evaluated: the next `wp_status` is zero and no counter increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mp_hit | input | NUM_MP | Matchpoint hits for watchpoints 0..NUM_MP-1 |
| ext_wp | input | 1 | External watchpoint condition (last watchpoint) |
| ifetch | input | 1 | Instruction fetch in this cycle |
| dbg_en | input | 1 | Global debug enable |
| in_reset | input | 1 | Processor held in reset |
| single_step | input | 1 | Break on every instruction fetch |
| chain_mode | input | 2*NUM_WP | Two-bit chain mode per watchpoint |
| cnt_assign | input | NUM_WP | Counter routing per watchpoint |
| brk_gen | input | NUM_WP | Break-generate enable per watchpoint |
| cnt_en | input | 2 | Counter increment enables |
| cnt_wr | input | 2 | Counter load strobes |
| cnt_wdata | input | 2*CNT_W | Load value: match in high half, count in low half |
| brk_req | output | 1 | Registered debug break request |
| wp_status | output | NUM_WP | Registered per-cycle watchpoint status |
| cnt_value | output | 4*CNT_W | Counter 1 in the high word, counter 0 in the low word |

## Verification
The chain is driven with sparse and dense hit vectors under each mode. Sparse hits under AND separate a broken predecessor link from a broken own term. Dense hits under OR show whether a hit carries along the chain or stops at the first mode-0 link. Counter tests load values one step below the match value and at 0xFFFF, so the feedback watchpoints 8 and 9 and the wrap can be seen. Several watchpoints routed to one counter show whether it is bumped once or once per watchpoint. Bursts of fetches with single-step, the disable and reset flags, and empty routing masks separate the three ways a break is suppressed or forced. A long random run with a reference model compares every output on every clock.

// File: rtl/dbg_wp_pkg.sv
// Shared types for the watchpoint chaining unit.
// Assumes chain mode fields are two bits wide.
package dbg_wp_pkg;

    typedef enum logic [1:0] {
        CHAIN_OWN  = 2'd0,
        CHAIN_AND  = 2'd1,
        CHAIN_OR   = 2'd2,
        CHAIN_NONE = 2'd3
    } chain_mode_e;

    // Combine a watchpoint's own condition with its predecessor per mode.
    function automatic logic chain_combine(chain_mode_e mode, logic own_c, logic prev_c);
        logic res;
        case (mode)
            CHAIN_OWN: res = own_c;
            CHAIN_AND: res = own_c & prev_c;
            CHAIN_OR:  res = own_c | prev_c;
            default:   res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/dbg_wp_link.sv
// Combinational watchpoint chain: each stage folds its own condition
// with the previous stage's result according to its mode.
// Assumes stage 0 uses its own condition as its predecessor.
// All outputs are forced low when eval_en is low.
module dbg_wp_link
    import dbg_wp_pkg::*;
#(
    parameter int NUM_WP = 11
) (
    input  logic [NUM_WP-1:0]   own_cond,
    input  logic [2*NUM_WP-1:0] mode_flat,
    input  logic                eval_en,
    output logic [NUM_WP-1:0]   wp_hit
);

    for (genvar i = 0; i < NUM_WP; i++) begin : g_stage
        logic stage_hit;
        logic prev_hit;
        if (i == 0) begin : g_first
            // First stage has no predecessor; it leans on itself.
            assign prev_hit = own_cond[0];
        end else begin : g_rest
            // Later stages lean on the stage before.
            assign prev_hit = g_stage[i-1].stage_hit;
        end
        // Fold own and predecessor per the stage's mode, gated by evaluation.
        assign stage_hit = eval_en &
                           chain_combine(chain_mode_e'(mode_flat[2*i +: 2]), own_cond[i], prev_hit);
        assign wp_hit[i] = stage_hit;
    end

endmodule

// File: rtl/dbg_wp_counter.sv
// One watchpoint counter: register with match value in the upper half
// and running count in the lower half. A load wins over an increment.
// The count wraps modulo 2**CNT_W; the match half only changes on load.
module dbg_wp_counter #(
    parameter int CNT_W = 16,
    localparam int REG_W = 2 * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic             bump,
    output logic [REG_W-1:0] value,
    output logic             reached
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] match_q;

    // Register update: reset, load, or single-step increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            match_q <= '0;
        end else if (load) begin
            count_q <= load_val[CNT_W-1:0];
            match_q <= load_val[REG_W-1:CNT_W];
        end else if (bump) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Expose the register and its count-reached-match condition.
    always_comb begin
        value   = {match_q, count_q};
        reached = (count_q == match_q);
    end

endmodule

// File: rtl/dbg_wp_break.sv
// Break decision: any matching watchpoint with break-generate set,
// or a fetch under single-step; all suppressed when not active.
module dbg_wp_break #(
    parameter int NUM_WP = 11
) (
    input  logic [NUM_WP-1:0] wp_hit,
    input  logic [NUM_WP-1:0] brk_gen,
    input  logic              single_step,
    input  logic              ifetch,
    input  logic              active,
    output logic              brk_next
);

    // Combine watchpoint breaks with single-step fetch breaks.
    always_comb begin
        brk_next = active & ((single_step & ifetch) | (|(wp_hit & brk_gen)));
    end

endmodule

// File: rtl/dbg_wp_chain.sv
// Watchpoint chaining and counter unit (top).
// Forms NUM_MP+3 watchpoints: matchpoint hits, two counter-reached
// conditions and one external line; chains them, drives two counters
// (each bumped at most once per cycle) and registers break and status.
// Assumes all configuration inputs are static or change synchronously.
module dbg_wp_chain
    import dbg_wp_pkg::*;
#(
    parameter int NUM_MP = 8,
    parameter int CNT_W  = 16,
    localparam int NUM_WP = NUM_MP + 3,
    localparam int REG_W  = 2 * CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MP-1:0]   mp_hit,
    input  logic                ext_wp,
    input  logic                ifetch,
    input  logic                dbg_en,
    input  logic                in_reset,
    input  logic                single_step,
    input  logic [2*NUM_WP-1:0] chain_mode,
    input  logic [NUM_WP-1:0]   cnt_assign,
    input  logic [NUM_WP-1:0]   brk_gen,
    input  logic [1:0]          cnt_en,
    input  logic [1:0]          cnt_wr,
    input  logic [REG_W-1:0]    cnt_wdata,
    output logic                brk_req,
    output logic [NUM_WP-1:0]   wp_status,
    output logic [2*REG_W-1:0]  cnt_value
);

    logic              active;
    logic              eval_en;
    logic [1:0]        cnt_reached;
    logic [1:0]        cnt_bump;
    logic [NUM_WP-1:0] own_cond;
    logic [NUM_WP-1:0] wp_hit;
    logic              brk_next;

    // Evaluation gating and own-condition assembly.
    always_comb begin
        active   = dbg_en & ~in_reset;
        eval_en  = active & ((|brk_gen) | (|cnt_assign));
        own_cond = {ext_wp, cnt_reached[1], cnt_reached[0], mp_hit};
    end

    dbg_wp_link #(.NUM_WP(NUM_WP)) link_i (
        .own_cond  (own_cond),
        .mode_flat (chain_mode),
        .eval_en   (eval_en),
        .wp_hit    (wp_hit)
    );

    for (genvar k = 0; k < 2; k++) begin : g_cnt
        logic [NUM_WP-1:0] routed;
        // Watchpoints routed to this counter by their assignment bit.
        assign routed      = (k == 1) ? cnt_assign : ~cnt_assign;
        assign cnt_bump[k] = cnt_en[k] & (|(wp_hit & routed));

        dbg_wp_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cnt_wr[k]),
            .load_val (cnt_wdata),
            .bump     (cnt_bump[k]),
            .value    (cnt_value[k*REG_W +: REG_W]),
            .reached  (cnt_reached[k])
        );
    end

    dbg_wp_break #(.NUM_WP(NUM_WP)) brk_i (
        .wp_hit      (wp_hit),
        .brk_gen     (brk_gen),
        .single_step (single_step),
        .ifetch      (ifetch),
        .active      (active),
        .brk_next    (brk_next)
    );

    // Output registers: status rebuilt every cycle, break request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req   <= 1'b0;
            wp_status <= '0;
        end else begin
            brk_req   <= brk_next;
            wp_status <= wp_hit;
        end
    end

endmodule

// File: rtl/dbg_wp_chain_chk.sv
// Assertion checker for dbg_wp_chain, attached by bind below.
// Observes only the top-level ports.
module dbg_wp_chain_chk #(
    parameter int NUM_MP = 8,
    parameter int CNT_W  = 16,
    localparam int NUM_WP = NUM_MP + 3,
    localparam int REG_W  = 2 * CNT_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ifetch,
    input logic                dbg_en,
    input logic                in_reset,
    input logic                single_step,
    input logic [NUM_WP-1:0]   cnt_assign,
    input logic [NUM_WP-1:0]   brk_gen,
    input logic [1:0]          cnt_wr,
    input logic                brk_req,
    input logic [NUM_WP-1:0]   wp_status,
    input logic [2*REG_W-1:0]  cnt_value
);

    AST_STEP_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && !in_reset && single_step && ifetch) |=> brk_req); // R7

    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_en || in_reset) |=> (!brk_req && wp_status == '0)); // R8

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((!dbg_en || in_reset) && cnt_wr == 2'b00) |=> $stable(cnt_value)); // R8

    AST_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_gen == '0 && cnt_assign == '0) |=> (wp_status == '0)); // R9

    AST_BRK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && !in_reset && !(single_step && ifetch))
        |=> (brk_req == |(wp_status & $past(brk_gen)))); // R6

    AST_CNT0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr[0] |=> (cnt_value[CNT_W-1:0] == $past(cnt_value[CNT_W-1:0]) ||
                        cnt_value[CNT_W-1:0] == CNT_W'($past(cnt_value[CNT_W-1:0]) + 1'b1))); // R4

    AST_CNT1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr[1] |=> (cnt_value[REG_W +: CNT_W] == $past(cnt_value[REG_W +: CNT_W]) ||
                        cnt_value[REG_W +: CNT_W] == CNT_W'($past(cnt_value[REG_W +: CNT_W]) + 1'b1))); // R4

    AST_MATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr == 2'b00) |=> ($stable(cnt_value[REG_W-1:CNT_W]) &&
                               $stable(cnt_value[2*REG_W-1:REG_W+CNT_W]))); // R4

endmodule

bind dbg_wp_chain dbg_wp_chain_chk #(.NUM_MP(NUM_MP), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ifetch      (ifetch),
    .dbg_en      (dbg_en),
    .in_reset    (in_reset),
    .single_step (single_step),
    .cnt_assign  (cnt_assign),
    .brk_gen     (brk_gen),
    .cnt_wr      (cnt_wr),
    .brk_req     (brk_req),
    .wp_status   (wp_status),
    .cnt_value   (cnt_value)
);

// File: tb/dbg_wp_chain_tb_top.sv
module dbg_wp_chain_tb_top;

    localparam int NMP  = 8;
    localparam int NWP  = NMP + 3;
    localparam int CW   = 16;
    localparam int RW   = 2 * CW;
    localparam int MASK = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NMP-1:0]  mp_hit = '0;
    logic            ext_wp = 1'b0;
    logic            ifetch = 1'b0;
    logic            dbg_en = 1'b0;
    logic            in_reset = 1'b0;
    logic            single_step = 1'b0;
    logic [2*NWP-1:0] chain_mode = '0;
    logic [NWP-1:0]  cnt_assign = '0;
    logic [NWP-1:0]  brk_gen = '0;
    logic [1:0]      cnt_en = '0;
    logic [1:0]      cnt_wr = '0;
    logic [RW-1:0]   cnt_wdata = '0;
    logic            brk_req;
    logic [NWP-1:0]  wp_status;
    logic [2*RW-1:0] cnt_value;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int m_cnt[2];
    int m_match[2];
    logic           e_brk;
    logic [NWP-1:0] e_status;

    always #5 clk = ~clk;

    dbg_wp_chain #(.NUM_MP(NMP), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mp_hit(mp_hit), .ext_wp(ext_wp),
        .ifetch(ifetch), .dbg_en(dbg_en), .in_reset(in_reset),
        .single_step(single_step), .chain_mode(chain_mode),
        .cnt_assign(cnt_assign), .brk_gen(brk_gen), .cnt_en(cnt_en),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .brk_req(brk_req),
        .wp_status(wp_status), .cnt_value(cnt_value)
    );

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model the edge for the current inputs, then compare at the next negedge.
    task automatic cycle();
        int w[NWP];
        int own, prv, md, act_on, ev, hit_brk;
        int bump[2];
        act_on = (dbg_en && !in_reset) ? 1 : 0;
        ev = (act_on != 0 && (brk_gen != 0 || cnt_assign != 0)) ? 1 : 0;
        hit_brk = 0;
        bump[0] = 0; bump[1] = 0;
        for (int i = 0; i < NWP; i++) begin
            if (i < NMP)       own = mp_hit[i];
            else if (i == NMP) own = (m_cnt[0] == m_match[0]) ? 1 : 0;
            else if (i == NMP + 1) own = (m_cnt[1] == m_match[1]) ? 1 : 0;
            else               own = ext_wp;
            prv = (i == 0) ? own : w[i-1];
            md = int'(chain_mode[2*i +: 2]);
            if (md == 0)      w[i] = own;
            else if (md == 1) w[i] = own & prv;
            else if (md == 2) w[i] = own | prv;
            else              w[i] = 0;
            if (ev == 0) w[i] = 0;
            if (w[i] != 0 && brk_gen[i]) hit_brk = 1;
            if (w[i] != 0 && cnt_en[cnt_assign[i]]) bump[cnt_assign[i]] = 1;
        end
        if (!rst_n) begin
            e_brk = 0; e_status = '0;
            for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_match[k] = 0; end
        end else begin
            e_brk = (act_on != 0 && ((single_step && ifetch) || hit_brk != 0));
            for (int i = 0; i < NWP; i++) e_status[i] = (w[i] != 0);
            for (int k = 0; k < 2; k++) begin
                if (cnt_wr[k]) begin
                    m_cnt[k] = int'(cnt_wdata[CW-1:0]);
                    m_match[k] = int'(cnt_wdata[RW-1:CW]);
                end else if (bump[k] != 0) begin
                    m_cnt[k] = (m_cnt[k] + 1) & MASK;
                end
            end
        end
        @(negedge clk);
        check("R6 R7 R8", "brk_req", longint'(brk_req), longint'(e_brk));
        check("R2 R3 R9", "wp_status", longint'(wp_status), longint'(e_status));
        check("R4 R5", "counter0", longint'(cnt_value[RW-1:0]),
              (longint'(m_match[0]) << CW) | longint'(m_cnt[0]));
        check("R4 R5", "counter1", longint'(cnt_value[2*RW-1:RW]),
              (longint'(m_match[1]) << CW) | longint'(m_cnt[1]));
    endtask

    task automatic load(int k, int match_v, int count_v);
        cnt_wr = '0;
        cnt_wr[k] = 1'b1;
        cnt_wdata = {CW'(match_v), CW'(count_v)};
        cycle();
        cnt_wr = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin : main
        m_cnt[0] = 0; m_cnt[1] = 0; m_match[0] = 0; m_match[1] = 0;
        repeat (3) cycle();
        // R1: reset state
        check("R1", "reset brk_req", longint'(brk_req), 0);
        check("R1", "reset wp_status", longint'(wp_status), 0);
        check("R1", "reset counters", longint'(cnt_value), 0);
        rst_n = 1'b1;
        dbg_en = 1'b1;
        cnt_en = 2'b00;

        // R2 R3: chain modes with break-generate on all watchpoints
        brk_gen = '1;
        load(0, 5, 0);
        load(1, 5, 0);
        chain_mode = '0;
        mp_hit = 8'b0000_0101; cycle();
        for (int i = 0; i < NWP; i++) chain_mode[2*i +: 2] = 2'd1;
        mp_hit = 8'b1111_1111; cycle();
        mp_hit = 8'b1110_1111; cycle();
        for (int i = 0; i < NWP; i++) chain_mode[2*i +: 2] = 2'd2;
        mp_hit = 8'b0000_0010; cycle();
        ext_wp = 1'b1; mp_hit = '0; cycle();
        ext_wp = 1'b0;
        for (int i = 0; i < NWP; i++) chain_mode[2*i +: 2] = 2'd3;
        mp_hit = '1; ext_wp = 1'b1; cycle();
        ext_wp = 1'b0;
        chain_mode = '0; chain_mode[2*3 +: 2] = 2'd1; chain_mode[2*5 +: 2] = 2'd2;
        mp_hit = 8'b0001_1000; cycle();
        mp_hit = 8'b0001_0000; cycle();

        // R4: counting, once per cycle with several watchpoints routed
        brk_gen = '0; chain_mode = '0; cnt_assign = 11'b000_1111_0000;
        cnt_en = 2'b11;
        mp_hit = 8'b1111_1111; cycle();
        mp_hit = 8'b0000_0011; cycle();
        mp_hit = 8'b0011_0000; cycle();
        cnt_en = 2'b01; mp_hit = 8'b1111_1111; cycle();
        // R2: counter reaching match fires watchpoint 8
        load(0, 3, 2);
        cnt_en = 2'b11; mp_hit = 8'b0000_0001; cycle();
        mp_hit = '0; brk_gen[NMP] = 1'b1; cycle(); cycle();
        // R4: wrap from 0xFFFF
        load(1, 0, MASK);
        mp_hit = 8'b0001_0000; cycle();
        mp_hit = '0; cycle();
        // R5: load wins over a bump
        mp_hit = 8'b0000_0001;
        cnt_wr = 2'b01; cnt_wdata = {CW'(16'h0040), CW'(16'h0010)}; cycle();
        cnt_wr = 2'b00; cycle();

        // R7: single step forces break on fetch
        brk_gen = '0; cnt_assign = '0; mp_hit = '0; single_step = 1'b1;
        ifetch = 1'b1; cycle(); ifetch = 1'b0; cycle(); ifetch = 1'b1; cycle();

        // R8: disable and in-reset suppress everything
        brk_gen = '1; cnt_assign = '1; mp_hit = '1;
        dbg_en = 1'b0; cycle(); cycle();
        dbg_en = 1'b1; in_reset = 1'b1; cycle(); cycle();
        in_reset = 1'b0; single_step = 1'b0; ifetch = 1'b0;

        // R9: empty routing and break masks disable evaluation
        brk_gen = '0; cnt_assign = '0; cnt_en = 2'b11; mp_hit = '1; cycle(); cycle();

        // Random run across all inputs
        for (int n = 0; n < 4000; n++) begin
            mp_hit      = NMP'($urandom & $urandom);
            ext_wp      = ($urandom_range(0, 3) == 0);
            ifetch      = $urandom_range(0, 1);
            dbg_en      = ($urandom_range(0, 15) != 0);
            in_reset    = ($urandom_range(0, 15) == 0);
            single_step = ($urandom_range(0, 7) == 0);
            chain_mode  = (2*NWP)'({$urandom, $urandom});
            cnt_assign  = NWP'($urandom);
            brk_gen     = ($urandom_range(0, 7) == 0) ? '0 : NWP'($urandom);
            cnt_en      = 2'($urandom);
            cnt_wr      = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
            cnt_wdata   = {CW'($urandom_range(0, 6)), CW'($urandom_range(0, 4))};
            if ($urandom_range(0, 63) == 0) cnt_wdata[CW-1:0] = CW'(MASK);
            cycle();
        end
        cnt_wr = '0;
        summary();
    end

endmodule